// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a host bus reach a small file of byte-wide configuration registers through two 32-bit windows. The host places a 7-bit register index and a data byte in the control window. When it also sets the start bit, the byte is committed to the selected register a fixed number of cycles later. During that time the start bit reads back as a busy flag.

Reads take a different path. The host writes the control window with the start bit clear, which selects the register to observe. The byte then appears in the data window after a fixed pipeline delay. The data window also shows the live level of the interrupt request line.

Index 0 is a read-only status byte that is taken from an input. Indices 1 to 27 are storage with fixed reset values. Indices above 27 behave as empty locations.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset the busy flag (control window bit 16) is 0, and the control window reads back index 0 and data byte 0.
- R2: A control-window write (offset 0x00) with bit 16 clear latches the index from bits 14:8 and the byte from bits 7:0. Both read back in the same bit positions, and no register changes.
- R3: A control-window write with bit 16 set raises the busy flag for exactly 4 cycles. The selected register holds the byte once the flag clears.
- R4: Any control-window write that arrives while the busy flag is 1 is ignored. This covers the latched index, the latched byte and any new start request.
- R5: The data window (offset 0x04) bits 7:0 show the selected register exactly 6 cycles after the index is latched. Until then they keep their previous value.
- R6: Data window bit 8 equals the interrupt input in the same cycle. Bits 31:9 of the data window read 0.
- R7: After reset, indices 0..27 read 00 FC 1B 20 00 80 00 00 FF 1F 3F 00 06 06 06 06 00 00 00 00 00 34 07 44 1F 00 00 00 in index order. Index 0 reads 00 when the status input is 00.
- R8: Index 0 reads the status input, and writes to index 0 are ignored.
- R9: Indices 28..127 read 0x00, and writes to them alter no register.
- R10: Writes to the data-window offset or to any other offset change nothing. Offsets other than 0x00 and 0x04 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write when 1, read otherwise |
| bus_addr | input | 3 | Byte offset of the window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Window read data for bus_addr (combinational) |
| irq_in | input | 1 | Interrupt request level mirrored to the data window |
| status_in | input | 8 | Value returned for index 0 |

## Verification
The hardest case to reach is a second control write that lands inside the 4-cycle commit window. The bench issues a start write and then, on the very next cycle, a start write to a different index with different data. It then confirms that only the first write took effect.

The read latency boundary is checked one cycle before and one cycle after the 6-cycle point, with two registers whose values differ. This makes a stale value and a fresh value distinguishable.

All 128 indices are swept for reads, with writes aimed at them as well. The expected value for each register is computed from an arithmetic pattern.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;
   localparam int unsigned CB_REG_COUNT  = 28;
   localparam int unsigned CB_IDX_W      = 7;
   localparam int unsigned CB_BYTE_W     = 8;
   localparam int unsigned CB_BUS_W      = 32;
   localparam int unsigned CB_OFF_W      = 3;
   localparam int unsigned CB_START_BIT  = 16;
   localparam int unsigned CB_IDX_LSB    = 8;
   localparam int unsigned CB_IRQ_BIT    = 8;
   localparam logic [CB_OFF_W-1:0] CB_OFF_CTRL = 3'h0;
   localparam logic [CB_OFF_W-1:0] CB_OFF_DATA = 3'h4;

   function automatic logic [7:0] cb_reset_value(input int unsigned idx);
      logic [7:0] v;
      case (idx)
         1:       v = 8'hFC;
         2:       v = 8'h1B;
         3:       v = 8'h20;
         5:       v = 8'h80;
         8:       v = 8'hFF;
         9:       v = 8'h1F;
         10:      v = 8'h3F;
         12, 13, 14, 15: v = 8'h06;
         21:      v = 8'h34;
         22:      v = 8'h07;
         23:      v = 8'h44;
         24:      v = 8'h1F;
         default: v = 8'h00;
      endcase
      return v;
   endfunction
endpackage

// File: rtl/cbr_access_ctl.sv
module cbr_access_ctl #(
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned START_B = 16,
   parameter int unsigned IDX_LSB = 8,
   parameter int unsigned WR_LAT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [BUS_W-1:0]  ctrl_wdata,
   output logic [IDX_W-1:0]  sel_idx,
   output logic [BYTE_W-1:0] sel_byte,
   output logic              busy,
   output logic              commit
);
   localparam int unsigned CNT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_LAT - 1);

   generate
      if (WR_LAT < 1) begin : g_bad_lat
         $error("WR_LAT must be at least 1");
      end
      if (IDX_LSB + IDX_W > START_B || BYTE_W > IDX_LSB || START_B >= BUS_W) begin : g_bad_map
         $error("control window fields overlap or exceed the bus");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             accept;

   assign accept = ctrl_we && !busy;
   assign commit = busy && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_idx  <= '0;
         sel_byte <= '0;
         busy     <= 1'b0;
         cnt_q    <= '0;
      end else begin
         if (accept) begin
            sel_idx  <= ctrl_wdata[IDX_LSB +: IDX_W];
            sel_byte <= ctrl_wdata[BYTE_W-1:0];
            if (ctrl_wdata[START_B]) begin
               busy  <= 1'b1;
               cnt_q <= CNT_LOAD;
            end
         end else if (commit) begin
            busy <= 1'b0;
         end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbr_reg_file.sv
module cbr_reg_file
   import codec_bridge_pkg::*;
#(
   parameter int unsigned REG_COUNT = 28,
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned BYTE_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] status_in,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic [BYTE_W-1:0] rd_byte
);
   localparam int unsigned SLOT_W = $clog2(REG_COUNT);
   localparam int unsigned SLOTS  = 1 << SLOT_W;

   generate
      if (REG_COUNT < 2) begin : g_bad_count
         $error("REG_COUNT must be at least 2");
      end
      if (IDX_W <= SLOT_W) begin : g_bad_idx
         $error("IDX_W must exceed the slot index width");
      end
   endgenerate

   logic [BYTE_W-1:0] slot_val [SLOTS];
   logic              idx_high;

   assign idx_high = |idx[IDX_W-1:SLOT_W];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i == 0) begin : g_status
         assign slot_val[i] = status_in;
      end else if (i < REG_COUNT) begin : g_store
         localparam logic [BYTE_W-1:0] RST_V = BYTE_W'(cb_reset_value(i));
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= RST_V;
            else if (wr_en && !idx_high && idx[SLOT_W-1:0] == SLOT_W'(i))
               q <= wr_byte;
         end
         assign slot_val[i] = q;
      end else begin : g_empty
         assign slot_val[i] = '0;
      end
   end

   assign rd_byte = idx_high ? '0 : slot_val[idx[SLOT_W-1:0]];
endmodule

// File: rtl/cbr_read_pipe.sv
module cbr_read_pipe #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned RD_LAT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout
);
   generate
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
   endgenerate

   logic [BYTE_W-1:0] stage [RD_LAT];

   for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)
            stage[s] <= '0;
         else if (s == 0)
            stage[s] <= din;
         else
            stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = stage[RD_LAT-1];
endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
   import codec_bridge_pkg::*;
#(
   parameter int unsigned REG_COUNT = CB_REG_COUNT,
   parameter int unsigned WR_LAT    = 4,
   parameter int unsigned RD_LAT    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [CB_OFF_W-1:0] bus_addr,
   input  logic [CB_BUS_W-1:0] bus_wdata,
   output logic [CB_BUS_W-1:0] bus_rdata,
   input  logic                irq_in,
   input  logic [CB_BYTE_W-1:0] status_in
);
   logic                 ctrl_we;
   logic [CB_IDX_W-1:0]  sel_idx;
   logic [CB_BYTE_W-1:0] sel_byte;
   logic                 busy;
   logic                 commit;
   logic [CB_BYTE_W-1:0] rf_rdata;
   logic [CB_BYTE_W-1:0] pipe_out;

   assign ctrl_we = bus_sel && bus_wr && (bus_addr == CB_OFF_CTRL);

   cbr_access_ctl #(
      .IDX_W(CB_IDX_W), .BYTE_W(CB_BYTE_W), .BUS_W(CB_BUS_W),
      .START_B(CB_START_BIT), .IDX_LSB(CB_IDX_LSB), .WR_LAT(WR_LAT)
   ) i_ctl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(bus_wdata),
      .sel_idx(sel_idx), .sel_byte(sel_byte), .busy(busy), .commit(commit)
   );

   cbr_reg_file #(
      .REG_COUNT(REG_COUNT), .IDX_W(CB_IDX_W), .BYTE_W(CB_BYTE_W)
   ) i_rf (
      .clk(clk), .rst_n(rst_n), .status_in(status_in), .wr_en(commit),
      .idx(sel_idx), .wr_byte(sel_byte), .rd_byte(rf_rdata)
   );

   cbr_read_pipe #(
      .BYTE_W(CB_BYTE_W), .RD_LAT(RD_LAT)
   ) i_pipe (
      .clk(clk), .rst_n(rst_n), .din(rf_rdata), .dout(pipe_out)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         CB_OFF_CTRL: begin
            bus_rdata[CB_START_BIT]               = busy;
            bus_rdata[CB_IDX_LSB +: CB_IDX_W]     = sel_idx;
            bus_rdata[CB_BYTE_W-1:0]              = sel_byte;
         end
         CB_OFF_DATA: begin
            bus_rdata[CB_IRQ_BIT]                 = irq_in;
            bus_rdata[CB_BYTE_W-1:0]              = pipe_out;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/codec_reg_bridge_chk.sv
module codec_reg_bridge_chk
   import codec_bridge_pkg::*;
#(
   parameter int unsigned REG_COUNT = CB_REG_COUNT,
   parameter int unsigned WR_LAT    = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ctrl_we,
   input logic [CB_BUS_W-1:0]  bus_wdata,
   input logic                 busy,
   input logic [CB_IDX_W-1:0]  sel_idx,
   input logic [CB_BYTE_W-1:0] rf_rdata,
   input logic [CB_OFF_W-1:0]  bus_addr,
   input logic [CB_BUS_W-1:0]  bus_rdata,
   input logic                 irq_in
);
   int unsigned busy_span;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) busy_span <= 0;
      else                 busy_span <= busy_span + 1;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_span == WR_LAT); // R3
   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(ctrl_we && bus_wdata[CB_START_BIT])); // R3
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_we) |=> $stable(sel_idx)); // R4
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_idx >= CB_IDX_W'(REG_COUNT)) |-> rf_rdata == '0); // R9
   AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CB_OFF_DATA) |-> (bus_rdata[CB_IRQ_BIT] == irq_in
                                     && bus_rdata[CB_BUS_W-1:CB_IRQ_BIT+1] == '0)); // R6
endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(
   .REG_COUNT(REG_COUNT), .WR_LAT(WR_LAT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .bus_wdata(bus_wdata),
   .busy(busy), .sel_idx(sel_idx), .rf_rdata(rf_rdata), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq_in(irq_in)
);

// File: tb/test_codec_reg_bridge.sv
`timescale 1ns/1ps
module test_codec_reg_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'h0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_in = 1'b0;
   logic [7:0]  status_in = 8'h00;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   localparam logic [7:0] RST_TBL [28] = '{
      8'h00, 8'hFC, 8'h1B, 8'h20, 8'h00, 8'h80, 8'h00, 8'h00,
      8'hFF, 8'h1F, 8'h3F, 8'h00, 8'h06, 8'h06, 8'h06, 8'h06,
      8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h34, 8'h07, 8'h44,
      8'h1F, 8'h00, 8'h00, 8'h00};

   always #2.5 clk = ~clk;

   codec_reg_bridge i_codec_reg_bridge (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .status_in(status_in));

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 8'hFF);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] off, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [2:0] off, output logic [31:0] d);
      bus_addr = off;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      bus_read(3'h0, d);
      while (d[16]) begin
         @(negedge clk);
         bus_read(3'h0, d);
      end
   endtask

   task automatic read_reg(input int idx, output logic [7:0] v);
      logic [31:0] d;
      wait_idle();
      bus_write(3'h0, 32'(idx) << 8);
      repeat (6) @(negedge clk);
      bus_read(3'h4, d);
      v = d[7:0];
   endtask

   task automatic write_reg(input int idx, input logic [7:0] v);
      wait_idle();
      bus_write(3'h0, (32'h1 << 16) | (32'(idx) << 8) | 32'(v));
      wait_idle();
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  v;
      int          span;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(3'h0, d);
      check("R1", d, 32'h0);

      // R7 reset values over all stored indices, R9 empty indices read zero
      for (int i = 0; i < 128; i++) begin
         read_reg(i, v);
         if (i < 28) check("R7", {24'h0, v}, {24'h0, RST_TBL[i]});
         else        check("R9", {24'h0, v}, 32'h0);
      end

      // R2 latch without start bit
      bus_write(3'h0, 32'h0000_0D5A);
      bus_read(3'h0, d);
      check("R2", d, 32'h0000_0D5A);
      repeat (6) @(negedge clk);
      bus_read(3'h4, d);
      check("R2", {24'h0, d[7:0]}, {24'h0, RST_TBL[13]});

      // R3 busy span
      wait_idle();
      bus_write(3'h0, 32'h0001_0977);
      span = 0;
      bus_read(3'h0, d);
      while (d[16] && span < 20) begin
         span++;
         @(negedge clk);
         bus_read(3'h0, d);
      end
      check("R3", 32'(span), 32'd4);
      read_reg(9, v);
      check("R3", {24'h0, v}, 32'h77);

      // R3 write pattern to all stored indices, R8 index 0 ignored
      for (int i = 0; i < 28; i++) write_reg(i, pat(i));
      // R9 writes to empty indices discarded
      for (int i = 28; i < 128; i++) write_reg(i, 8'hA5);
      status_in = 8'h00;
      for (int i = 0; i < 28; i++) begin
         read_reg(i, v);
         if (i == 0) check("R8", {24'h0, v}, 32'h0);
         else        check("R3", {24'h0, v}, {24'h0, pat(i)});
      end
      status_in = 8'h5A;
      read_reg(0, v);
      check("R8", {24'h0, v}, 32'h5A);

      // R4 second start inside the commit window
      wait_idle();
      bus_write(3'h0, 32'h0001_05C3);
      bus_write(3'h0, 32'h0001_063C);
      bus_read(3'h0, d);
      check("R4", d, 32'h0001_05C3);
      wait_idle();
      read_reg(5, v);
      check("R4", {24'h0, v}, 32'hC3);
      read_reg(6, v);
      check("R4", {24'h0, v}, {24'h0, pat(6)});

      // R5 latency boundary: index 7 then index 8
      read_reg(7, v);
      bus_write(3'h0, 32'h0000_0800);
      repeat (5) @(negedge clk);
      bus_read(3'h4, d);
      check("R5", {24'h0, d[7:0]}, {24'h0, pat(7)});
      @(negedge clk);
      bus_read(3'h4, d);
      check("R5", {24'h0, d[7:0]}, {24'h0, pat(8)});

      // R6 interrupt mirror
      irq_in = 1'b1;
      bus_read(3'h4, d);
      check("R6", d, {23'h0, 1'b1, pat(8)});
      irq_in = 1'b0;
      bus_read(3'h4, d);
      check("R6", d, {23'h0, 1'b0, pat(8)});

      // R10 writes to other offsets have no effect
      bus_write(3'h4, 32'h0001_0811);
      bus_write(3'h2, 32'h0001_0822);
      bus_read(3'h0, d);
      check("R10", d, 32'h0000_0800);
      bus_read(3'h2, d);
      check("R10", d, 32'h0);
      repeat (8) @(negedge clk);
      bus_read(3'h4, d);
      check("R10", {24'h0, d[7:0]}, {24'h0, pat(8)});

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule